// File: doc/BRIEF.md
# Packet Forwarding Decision Unit

The unit takes one IPv4 header per cycle as a parallel descriptor: destination, source, protocol, both transport ports, TTL and header checksum. It returns exactly one verdict for each descriptor. The destination goes through a longest-prefix search of a small route table. The source, protocol and ports are compared against a filter rule set. The TTL is decremented. The outcome is one of three: forward on an egress port, drop silently, or hand the packet to the slow path with a reason code so that an ICMP message can be built there.

Software fills both tables through two write ports. Each write ports takes a whole entry in one cycle. Each discard reason (filter, unreachable destination, TTL expiry) has its own configuration input. That input selects between a silent drop and a punt. On a forward, the unit emits the new TTL and a checksum patched incrementally. Descriptors flow through a two-stage pipeline with a valid/ready handshake on both sides.

Top module: `pkt_fwd_unit`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and all route entries and filter rules are invalid. A descriptor sent before any table write therefore gets reason 1 (unreachable).
- R2: A valid route entry matches when (dst AND mask) equals (entry address AND mask). Masks are contiguous. Among matching entries, the one with the numerically largest mask wins, and on equal masks the lowest index wins.
- R3: When no valid route entry matches, the reason is 1 (destination unreachable).
- R4: A winning route entry with its discard flag set gives reason 1. For every reason-1 discard, cfg_unreach_icmp=1 gives verdict 2 (punt) and 0 gives verdict 1 (silent drop).
- R5: out_ttl is in_ttl-1, or 0 when in_ttl is 0. An in_ttl of 0 or 1 is an expiry with reason 2, and cfg_ttl_icmp picks punt (1) or silent drop (0).
- R6: A filter rule matches when it is valid and every field it enables matches. Enable bit 0 compares the source, bit 1 the protocol, and bit 2 the port against either transport port. A match gives reason 3, and cfg_flt_icmp picks punt (1) or drop (0). A rule that is not valid has no effect.
- R7: Precedence is filter, then route discard or no match, then TTL expiry, then forward.
- R8: A forward has verdict 0, reason 0 and the winning entry's egress port in out_port. out_csum is ~(~csum +' 16'hFEFF), where +' is ones-complement addition with the end-around carry.
- R9: A descriptor accepted at a clock edge shows up on the output after the second edge. With out_ready held high, one descriptor is accepted every cycle.
- R10: While out_valid is high and out_ready is low, every output field stays stable. Once both stages are full, in_ready drops.
- R11: A table write in the same cycle as an accept, or later, leaves that descriptor's verdict unchanged. It applies to descriptors accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_unreach_icmp | input | 1 | Punt (1) or drop (0) on reason 1 |
| cfg_ttl_icmp | input | 1 | Punt (1) or drop (0) on reason 2 |
| cfg_flt_icmp | input | 1 | Punt (1) or drop (0) on reason 3 |
| rt_wr_en | input | 1 | Route entry write strobe |
| rt_wr_idx | input | 4 | Route entry index |
| rt_wr_vld | input | 1 | Entry valid |
| rt_wr_addr | input | 32 | Entry prefix address |
| rt_wr_mask | input | 32 | Entry prefix mask |
| rt_wr_port | input | 3 | Entry egress port |
| rt_wr_drop | input | 1 | Entry discard flag |
| fl_wr_en | input | 1 | Filter rule write strobe |
| fl_wr_idx | input | 3 | Filter rule index |
| fl_wr_vld | input | 1 | Rule valid |
| fl_wr_use | input | 3 | Field enables: bit0 source, bit1 protocol, bit2 port |
| fl_wr_src | input | 32 | Rule source address |
| fl_wr_proto | input | 8 | Rule protocol |
| fl_wr_port | input | 16 | Rule transport port |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high together with in_valid |
| in_dst | input | 32 | Destination address |
| in_src | input | 32 | Source address |
| in_proto | input | 8 | IP protocol |
| in_sport | input | 16 | Source transport port |
| in_dport | input | 16 | Destination transport port |
| in_ttl | input | 8 | Time to live |
| in_csum | input | 16 | Header checksum |
| out_valid | output | 1 | Verdict valid |
| out_ready | input | 1 | Verdict consumed when high together with out_valid |
| out_verdict | output | 2 | 0 forward, 1 silent drop, 2 punt |
| out_icmp | output | 2 | Reason: 0 none, 1 unreachable, 2 TTL expired, 3 filtered |
| out_port | output | 3 | Egress port on forward, else 0 |
| out_ttl | output | 8 | Decremented TTL |
| out_csum | output | 16 | Patched header checksum |

## Verification
The hold assertion assumes the consumer samples a verdict only while out_valid is high. It also assumes that a stalled result is read later, never dropped. The bench lowers out_ready only while it watches the held output. The route and filter checks assume route masks are contiguous and that writes come on their strobes alone. Every table image in the bench uses prefix-shaped masks, and the bench drives write fields only together with a strobe.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  typedef enum logic [1:0] {VD_FWD = 2'd0, VD_DROP = 2'd1, VD_PUNT = 2'd2} verdict_e;
  typedef enum logic [1:0] {RS_NONE = 2'd0, RS_UNREACH = 2'd1, RS_TTL = 2'd2, RS_FILT = 2'd3} reason_e;
endpackage

// File: rtl/pfu_route_lkup.sv
module pfu_route_lkup #(
  parameter int ENTRIES = 16,
  parameter int AW = 32,
  parameter int PW = 3,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_mask,
  input  logic [PW-1:0] wr_port,
  input  logic          wr_drop,
  input  logic [AW-1:0] key,
  output logic          hit,
  output logic [PW-1:0] port,
  output logic          drop
);
  logic [ENTRIES-1:0] ent_vld;
  logic [AW-1:0]      ent_addr [ENTRIES];
  logic [AW-1:0]      ent_mask [ENTRIES];
  logic [PW-1:0]      ent_port [ENTRIES];
  logic [ENTRIES-1:0] ent_drop;
  logic [ENTRIES-1:0] match;
  logic [AW-1:0]      best_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_vld <= '0;
    else if (wr_en) ent_vld[wr_idx] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_addr[wr_idx] <= wr_addr;
      ent_mask[wr_idx] <= wr_mask;
      ent_port[wr_idx] <= wr_port;
      ent_drop[wr_idx] <= wr_drop;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && ((key & ent_mask[g]) == (ent_addr[g] & ent_mask[g]));
  end

  always_comb begin
    hit = 1'b0;
    port = '0;
    drop = 1'b0;
    best_mask = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i] && (!hit || ent_mask[i] > best_mask)) begin
        hit = 1'b1;
        port = ent_port[i];
        drop = ent_drop[i];
        best_mask = ent_mask[i];
      end
    end
  end

  // R2
  rt_hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n) hit |-> (ent_vld != '0));
endmodule

// File: rtl/pfu_filter.sv
module pfu_filter #(
  parameter int RULES = 8,
  localparam int IW = $clog2(RULES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_vld,
  input  logic [2:0]    wr_use,
  input  logic [31:0]   wr_src,
  input  logic [7:0]    wr_proto,
  input  logic [15:0]   wr_port,
  input  logic [31:0]   src,
  input  logic [7:0]    proto,
  input  logic [15:0]   sport,
  input  logic [15:0]   dport,
  output logic          hit
);
  logic [RULES-1:0] r_vld;
  logic [2:0]       r_use   [RULES];
  logic [31:0]      r_src   [RULES];
  logic [7:0]       r_proto [RULES];
  logic [15:0]      r_port  [RULES];
  logic [RULES-1:0] r_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_vld <= '0;
    else if (wr_en) r_vld[wr_idx] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      r_use[wr_idx]   <= wr_use;
      r_src[wr_idx]   <= wr_src;
      r_proto[wr_idx] <= wr_proto;
      r_port[wr_idx]  <= wr_port;
    end
  end

  for (genvar g = 0; g < RULES; g++) begin : g_rule
    logic src_ok, proto_ok, port_ok;
    assign src_ok   = !r_use[g][0] || (src == r_src[g]);
    assign proto_ok = !r_use[g][1] || (proto == r_proto[g]);
    assign port_ok  = !r_use[g][2] || (sport == r_port[g]) || (dport == r_port[g]);
    assign r_hit[g] = r_vld[g] && src_ok && proto_ok && port_ok;
  end

  assign hit = |r_hit;

  // R6
  flt_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) hit |-> (r_vld != '0));
endmodule

// File: rtl/pfu_ttl_upd.sv
module pfu_ttl_upd (
  input  logic [7:0]  ttl_in,
  input  logic [15:0] csum_in,
  output logic [7:0]  ttl_out,
  output logic [15:0] csum_out,
  output logic        expired
);
  logic [16:0] sum;
  logic [15:0] fold;

  always_comb begin
    expired  = (ttl_in <= 8'd1);
    ttl_out  = (ttl_in == 8'd0) ? 8'd0 : ttl_in - 8'd1;
    sum      = {1'b0, ~csum_in} + 17'h0FEFF;
    fold     = sum[15:0] + {15'd0, sum[16]};
    csum_out = ~fold;
  end
endmodule

// File: rtl/pkt_fwd_unit.sv
module pkt_fwd_unit #(
  parameter int RT_N = 16,
  parameter int FL_N = 8,
  parameter int PW = 3,
  localparam int RT_IW = $clog2(RT_N),
  localparam int FL_IW = $clog2(FL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_unreach_icmp,
  input  logic             cfg_ttl_icmp,
  input  logic             cfg_flt_icmp,
  input  logic             rt_wr_en,
  input  logic [RT_IW-1:0] rt_wr_idx,
  input  logic             rt_wr_vld,
  input  logic [31:0]      rt_wr_addr,
  input  logic [31:0]      rt_wr_mask,
  input  logic [PW-1:0]    rt_wr_port,
  input  logic             rt_wr_drop,
  input  logic             fl_wr_en,
  input  logic [FL_IW-1:0] fl_wr_idx,
  input  logic             fl_wr_vld,
  input  logic [2:0]       fl_wr_use,
  input  logic [31:0]      fl_wr_src,
  input  logic [7:0]       fl_wr_proto,
  input  logic [15:0]      fl_wr_port,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_dst,
  input  logic [31:0]      in_src,
  input  logic [7:0]       in_proto,
  input  logic [15:0]      in_sport,
  input  logic [15:0]      in_dport,
  input  logic [7:0]       in_ttl,
  input  logic [15:0]      in_csum,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_verdict,
  output logic [1:0]       out_icmp,
  output logic [PW-1:0]    out_port,
  output logic [7:0]       out_ttl,
  output logic [15:0]      out_csum
);
  import pfu_pkg::*;

  logic          rt_hit, rt_drop, fl_hit, ttl_exp;
  logic [PW-1:0] rt_port;
  logic [7:0]    ttl_dec;
  logic [15:0]   csum_new;

  logic          s1_vld, s1_rt_hit, s1_rt_drop, s1_fl_hit, s1_exp;
  logic [PW-1:0] s1_port;
  logic [7:0]    s1_ttl;
  logic [15:0]   s1_csum;

  logic          en1, en2;
  verdict_e      vd_nx;
  reason_e       rs_nx;
  logic [PW-1:0] port_nx;

  pfu_route_lkup #(.ENTRIES(RT_N), .AW(32), .PW(PW)) u_route (
    .clk(clk), .rst_n(rst_n), .wr_en(rt_wr_en), .wr_idx(rt_wr_idx), .wr_vld(rt_wr_vld),
    .wr_addr(rt_wr_addr), .wr_mask(rt_wr_mask), .wr_port(rt_wr_port), .wr_drop(rt_wr_drop),
    .key(in_dst), .hit(rt_hit), .port(rt_port), .drop(rt_drop)
  );

  pfu_filter #(.RULES(FL_N)) u_filter (
    .clk(clk), .rst_n(rst_n), .wr_en(fl_wr_en), .wr_idx(fl_wr_idx), .wr_vld(fl_wr_vld),
    .wr_use(fl_wr_use), .wr_src(fl_wr_src), .wr_proto(fl_wr_proto), .wr_port(fl_wr_port),
    .src(in_src), .proto(in_proto), .sport(in_sport), .dport(in_dport), .hit(fl_hit)
  );

  pfu_ttl_upd u_ttl (
    .ttl_in(in_ttl), .csum_in(in_csum), .ttl_out(ttl_dec), .csum_out(csum_new), .expired(ttl_exp)
  );

  assign en2      = !out_valid || out_ready;
  assign en1      = !s1_vld || en2;
  assign in_ready = en1;

  // stage 1: capture lookup results at accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld <= 1'b0;
    else if (en1) s1_vld <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (en1 && in_valid) begin
      s1_rt_hit  <= rt_hit;
      s1_rt_drop <= rt_drop;
      s1_port    <= rt_port;
      s1_fl_hit  <= fl_hit;
      s1_exp     <= ttl_exp;
      s1_ttl     <= ttl_dec;
      s1_csum    <= csum_new;
    end
  end

  // stage 2 next state: verdict resolution by precedence
  always_comb begin
    port_nx = '0;
    if (s1_fl_hit) begin
      rs_nx = RS_FILT;
      vd_nx = cfg_flt_icmp ? VD_PUNT : VD_DROP;
    end else if (!s1_rt_hit || s1_rt_drop) begin
      rs_nx = RS_UNREACH;
      vd_nx = cfg_unreach_icmp ? VD_PUNT : VD_DROP;
    end else if (s1_exp) begin
      rs_nx = RS_TTL;
      vd_nx = cfg_ttl_icmp ? VD_PUNT : VD_DROP;
    end else begin
      rs_nx = RS_NONE;
      vd_nx = VD_FWD;
      port_nx = s1_port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (en2) out_valid <= s1_vld;
  end

  always_ff @(posedge clk) begin
    if (en2 && s1_vld) begin
      out_verdict <= vd_nx;
      out_icmp    <= rs_nx;
      out_port    <= port_nx;
      out_ttl     <= s1_ttl;
      out_csum    <= s1_csum;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_verdict) && $stable(out_icmp)
      && $stable(out_port) && $stable(out_ttl) && $stable(out_csum));
  // R8
  fwd_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_verdict == 2'd0 |-> out_icmp == 2'd0 && out_ttl != 8'd0);
  // R7
  disc_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_verdict != 2'd0 |-> out_icmp != 2'd0 && out_port == '0);
  // R9
  accept_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_vld);
  // R10
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld && out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/pkt_fwd_unit_tb.sv
module pkt_fwd_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_unreach_icmp, cfg_ttl_icmp, cfg_flt_icmp;
  logic rt_wr_en, rt_wr_vld, rt_wr_drop;
  logic [3:0] rt_wr_idx;
  logic [31:0] rt_wr_addr, rt_wr_mask;
  logic [2:0] rt_wr_port;
  logic fl_wr_en, fl_wr_vld;
  logic [2:0] fl_wr_idx, fl_wr_use;
  logic [31:0] fl_wr_src;
  logic [7:0] fl_wr_proto;
  logic [15:0] fl_wr_port;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_dst, in_src;
  logic [7:0] in_proto, in_ttl, out_ttl;
  logic [15:0] in_sport, in_dport, in_csum, out_csum;
  logic [1:0] out_verdict, out_icmp;
  logic [2:0] out_port;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  pkt_fwd_unit u_dut (.*);

  typedef struct packed {
    logic [31:0] dst; logic [31:0] src; logic [7:0] proto; logic [15:0] dport;
    logic [7:0] ttl; logic [1:0] vd; logic [1:0] rs; logic [2:0] port; logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0A090909, 32'h01020304, 8'd6,  16'd80, 8'd64, 2'd0, 2'd0, 3'd1, 4'd2}, // R2 /8
    '{32'h0A010505, 32'h01020304, 8'd6,  16'd80, 8'd64, 2'd0, 2'd0, 3'd2, 4'd2}, // R2 longer /16
    '{32'h0A010203, 32'h01020304, 8'd6,  16'd80, 8'd64, 2'd2, 2'd1, 3'd0, 4'd4}, // R4 discard entry
    '{32'h08080808, 32'h01020304, 8'd6,  16'd80, 8'd64, 2'd2, 2'd1, 3'd0, 4'd3}, // R3 no match
    '{32'hC0A80101, 32'h01020304, 8'd6,  16'd80, 8'd1,  2'd2, 2'd2, 3'd0, 4'd5}, // R5 expiry
    '{32'h0A010203, 32'h01020304, 8'd6,  16'd80, 8'd1,  2'd2, 2'd1, 3'd0, 4'd7}, // R7 route over ttl
    '{32'h0A090909, 32'hAC100009, 8'd6,  16'd80, 8'd64, 2'd1, 2'd3, 3'd0, 4'd6}, // R6 source rule
    '{32'h0A010203, 32'h01020304, 8'd17, 16'd53, 8'd64, 2'd1, 2'd3, 3'd0, 4'd7}, // R7 filter over route
    '{32'hC0A80303, 32'h01020304, 8'd6,  16'd53, 8'd64, 2'd0, 2'd0, 3'd5, 4'd6}, // R6 invalid rule ignored
    '{32'hC0A80303, 32'h01020304, 8'd6,  16'd80, 8'd2,  2'd0, 2'd0, 3'd5, 4'd5}, // R5 ttl 2 forwards
    '{32'hC0A80303, 32'h01020304, 8'd6,  16'd80, 8'd0,  2'd2, 2'd2, 3'd0, 4'd5}  // R5 ttl 0
  };

  function automatic logic [15:0] exp_csum(input logic [15:0] c);
    logic [31:0] s;
    s = {16'd0, ~c} + 32'h0000FEFF;
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return ~s[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  task automatic rt_write(input int idx, input logic [31:0] a, input logic [31:0] m, input int p, input bit d);
    @(negedge clk);
    rt_wr_en = 1; rt_wr_idx = 4'(idx); rt_wr_vld = 1; rt_wr_addr = a; rt_wr_mask = m;
    rt_wr_port = 3'(p); rt_wr_drop = d;
    @(negedge clk);
    rt_wr_en = 0;
  endtask

  task automatic fl_write(input int idx, input bit v, input logic [2:0] use_f, input logic [31:0] s, input logic [7:0] pr, input logic [15:0] pt);
    @(negedge clk);
    fl_wr_en = 1; fl_wr_idx = 3'(idx); fl_wr_vld = v; fl_wr_use = use_f;
    fl_wr_src = s; fl_wr_proto = pr; fl_wr_port = pt;
    @(negedge clk);
    fl_wr_en = 0;
  endtask

  task automatic drive(input logic [31:0] d, input logic [31:0] s, input logic [7:0] pr, input logic [15:0] dp, input logic [7:0] t);
    in_valid = 1; in_dst = d; in_src = s; in_proto = pr; in_dport = dp; in_sport = 16'd40000;
    in_ttl = t; in_csum = 16'h1234 + {8'd0, t};
  endtask

  task automatic wait_out();
    int k = 0;
    while (!out_valid && k < 50) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_one(input logic [31:0] d, input logic [31:0] s, input logic [7:0] pr, input logic [15:0] dp, input logic [7:0] t,
                         input logic [1:0] vd, input logic [1:0] rs, input logic [2:0] p, input string req);
    @(negedge clk);
    drive(d, s, pr, dp, t);
    @(negedge clk);
    in_valid = 0;
    wait_out();
    check(out_valid, req, "out_valid", 32'(out_valid), 1);
    check(out_verdict == vd, req, "verdict", 32'(out_verdict), 32'(vd));
    check(out_icmp == rs, req, "reason", 32'(out_icmp), 32'(rs));
    check(out_port == p, req, "port", 32'(out_port), 32'(p));
    check(out_ttl == ((t == 0) ? 8'd0 : t - 8'd1), req, "ttl", 32'(out_ttl), 32'((t == 0) ? 8'd0 : t - 8'd1));
    if (vd == 2'd0)
      check(out_csum == exp_csum(16'h1234 + {8'd0, t}), "R8", "csum", 32'(out_csum), 32'(exp_csum(16'h1234 + {8'd0, t})));
  endtask

  initial begin
    rst_n = 0; cfg_unreach_icmp = 1; cfg_ttl_icmp = 1; cfg_flt_icmp = 0;
    rt_wr_en = 0; rt_wr_idx = 0; rt_wr_vld = 0; rt_wr_addr = 0; rt_wr_mask = 0; rt_wr_port = 0; rt_wr_drop = 0;
    fl_wr_en = 0; fl_wr_idx = 0; fl_wr_vld = 0; fl_wr_use = 0; fl_wr_src = 0; fl_wr_proto = 0; fl_wr_port = 0;
    in_valid = 0; in_dst = 0; in_src = 0; in_proto = 0; in_sport = 0; in_dport = 0; in_ttl = 0; in_csum = 0;
    out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!out_valid, "R1", "out_valid", 32'(out_valid), 0);
    check(in_ready, "R1", "in_ready", 32'(in_ready), 1);
    run_one(32'h0A090909, 32'h01020304, 8'd6, 16'd80, 8'd64, 2'd2, 2'd1, 3'd0, "R1");

    rt_write(0, 32'h0A000000, 32'hFF000000, 1, 0);
    rt_write(1, 32'h0A010000, 32'hFFFF0000, 2, 0);
    rt_write(2, 32'h0A010200, 32'hFFFFFF00, 0, 1);
    rt_write(3, 32'hC0A80000, 32'hFFFF0000, 5, 0);
    rt_write(4, 32'hC0A80000, 32'hFFFF0000, 6, 0); // R2 tie: index 3 wins
    fl_write(0, 1, 3'b001, 32'hAC100009, 8'd0, 16'd0);
    fl_write(1, 1, 3'b110, 32'd0, 8'd17, 16'd53);
    fl_write(2, 0, 3'b010, 32'd0, 8'd6, 16'd0);

    for (int i = 0; i < NV; i++)
      run_one(VECS[i].dst, VECS[i].src, VECS[i].proto, VECS[i].dport, VECS[i].ttl,
              VECS[i].vd, VECS[i].rs, VECS[i].port, $sformatf("R%0d", VECS[i].req));

    // R4 silent unreachable, R5 silent expiry, R6 punt on filter
    cfg_unreach_icmp = 0; cfg_ttl_icmp = 0; cfg_flt_icmp = 1;
    run_one(32'h08080808, 32'h01020304, 8'd6, 16'd80, 8'd64, 2'd1, 2'd1, 3'd0, "R4");
    run_one(32'hC0A80101, 32'h01020304, 8'd6, 16'd80, 8'd1, 2'd1, 2'd2, 3'd0, "R5");
    run_one(32'h0A090909, 32'hAC100009, 8'd6, 16'd80, 8'd64, 2'd2, 2'd3, 3'd0, "R6");
    cfg_unreach_icmp = 1; cfg_ttl_icmp = 1; cfg_flt_icmp = 0;

    // R11 write in the accept cycle
    @(negedge clk);
    drive(32'h0A090909, 32'h01020304, 8'd6, 16'd80, 8'd64);
    rt_wr_en = 1; rt_wr_idx = 0; rt_wr_vld = 1; rt_wr_addr = 32'h0A000000; rt_wr_mask = 32'hFF000000;
    rt_wr_port = 3'd7; rt_wr_drop = 0;
    @(negedge clk);
    in_valid = 0; rt_wr_en = 0;
    wait_out();
    check(out_port == 3'd1, "R11", "in-flight port", 32'(out_port), 1);
    run_one(32'h0A090909, 32'h01020304, 8'd6, 16'd80, 8'd64, 2'd0, 2'd0, 3'd7, "R11");

    // R10 backpressure
    @(negedge clk);
    out_ready = 0;
    drive(32'hC0A80303, 32'h01020304, 8'd6, 16'd80, 8'd40);
    @(negedge clk);
    drive(32'hC0A80303, 32'h01020304, 8'd6, 16'd80, 8'd50);
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    check(out_valid && out_ttl == 8'd39, "R10", "first held ttl", 32'(out_ttl), 39);
    check(!in_ready, "R10", "in_ready stalled", 32'(in_ready), 0);
    repeat (3) @(negedge clk);
    check(out_valid && out_ttl == 8'd39 && out_port == 3'd5, "R10", "held after stall", 32'(out_ttl), 39);
    out_ready = 1;
    @(negedge clk);
    check(out_valid && out_ttl == 8'd49, "R10", "second after release", 32'(out_ttl), 49);
    @(negedge clk);
    check(!out_valid, "R10", "drained", 32'(out_valid), 0);

    // R9 throughput and latency
    for (int j = 0; j < 3; j++) begin
      drive(32'hC0A80303, 32'h01020304, 8'd6, 16'd80, 8'(10 * (j + 1)));
      check(in_ready, "R9", "in_ready streaming", 32'(in_ready), 1);
      @(negedge clk);
      if (j == 1) check(out_valid && out_ttl == 8'd9, "R9", "latency two", 32'(out_ttl), 9);
    end
    in_valid = 0;
    check(out_valid && out_ttl == 8'd19, "R9", "second back-to-back", 32'(out_ttl), 19);
    @(negedge clk);
    check(out_valid && out_ttl == 8'd29, "R9", "third back-to-back", 32'(out_ttl), 29);
    @(negedge clk);
    finish_run();
  end
endmodule